// File: doc/BRIEF.md
# DSP Burst Local-Bus Arbiter

This block sits between a DSP that writes bursts over its synchronous global bus and a bridge that owns a shared local bus. The DSP raises a request by pulling its strobe low together with at least one of its status lines; the arbiter waits until the bridge has finished whatever local-bus cycle it is running, and then hands the bus to the DSP by pulling the address and data enables low. While the DSP owns the bus, every word is acknowledged through an active-low ready and written into an input FIFO. The FIFO drains toward the bridge through a valid/ready handshake.

Ready is withheld whenever the FIFO has no room, so the DSP stalls instead of losing data. The DSP ends a burst by pulling status line 0 low on its final word, and the bus is released on the cycle after that word is taken. A bridge-side master that wants the local resources normally waits for the DSP. There is one exception: the DSP may be stalled by a full FIFO while the bridge side is itself waiting. That case would deadlock, so the arbiter serves the bridge side first and then hands the bus back to the DSP.

Top module: `lbus_burst_arb`

## Requirements
- R1: While reset is held and on the first cycle after it, both enables and ready are high (inactive), the bridge grant is low and the drain output is not valid.
- R2: A DSP request is strobe low together with at least one status line low. Strobe low with every status line high is idle and leaves the enables high.
- R3: After a request, the enables go low on the cycle after the first clock edge at which the bridge-busy input is low. While bridge-busy stays high, the enables stay high.
- R4: While the DSP owns the bus and the FIFO has room, ready is low. A word is taken at each clock edge where ready is low and a request is present.
- R5: When the FIFO holds its full depth (256 words by default), ready is high and no word is taken. Ready returns low on the cycle after a drain frees a slot, provided the DSP still owns the bus.
- R6: A word taken with status line 0 low (bit 0 of the status bus) is the last word of the burst. On the next cycle the enables and ready are high.
- R7: The DSP has priority. If both masters request at an idle edge, the DSP gets the bus. The bridge grant rises only when the arbiter is idle and the DSP is not requesting, and the grant and the DSP enables are never active together.
- R8: When the DSP owns the bus but is held off by a full FIFO, and the bridge side requests, the enables go high and the bridge grant goes high on the next cycle. When the bridge side withdraws its request, the arbiter re-grants to the DSP under the R3 rule.
- R9: Words leave the FIFO in the order they were taken. Drain-valid is high exactly when the FIFO is non-empty, and one word is removed at each edge where valid and drain-ready are both high.
- R10: The bridge grant falls on the cycle after the first edge at which the bridge-side request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock; every output changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dsp_strb_n | input | 1 | DSP strobe, active low |
| dsp_stat_n | input | STAT_W | DSP status lines, active low; all high means idle, bit 0 low marks the last word |
| dsp_wdata | input | DW | DSP write data |
| br_busy | input | 1 | Bridge is running a local-bus cycle |
| br_req | input | 1 | Bridge-side master wants the local resources |
| drain_ready | input | 1 | Bridge side accepts a FIFO word |
| dsp_ae_n | output | 1 | DSP address enable, active low |
| dsp_de_n | output | 1 | DSP data enable, active low |
| dsp_rdy_n | output | 1 | DSP ready, active low; a word is taken at the next edge |
| br_gnt | output | 1 | Local bus granted to the bridge side |
| drain_valid | output | 1 | FIFO holds a word |
| drain_data | output | DW | Oldest FIFO word |

## Verification
Every arbiter output is a register, so the enables, ready and the bridge grant each respond one edge after the inputs that cause them. The bench drives its inputs on the falling edge, lets its reference model step at the rising edge, and compares all outputs at the following falling edge, which is the cycle in which each result is due. Drain-valid and drain-data follow the FIFO contents after the same edge, because a word taken at an edge is readable in the next cycle. The scenario checks are placed the same way: the grant-wait, burst-end, full-FIFO and deadlock cases are each sampled at the falling edge that follows the edge that should cause them.

// File: rtl/lba_pkg.sv
package lba_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // nobody owns the bus
    ST_WAIT = 3'd1,  // DSP asked, bridge cycle still running
    ST_DSP  = 3'd2,  // DSP owns the bus
    ST_BRG  = 3'd3,  // bridge side owns the bus from idle
    ST_BRK  = 3'd4   // bridge side served to break a stall
  } arb_st_t;

endpackage

// File: rtl/lba_req_dec.sv
module lba_req_dec #(
  parameter int STAT_W = 4
) (
  input  logic              strb_n,
  input  logic [STAT_W-1:0] stat_n,
  output logic              req,
  output logic              last
);

  // a request needs the strobe and at least one status line low
  always_comb begin
    req  = !strb_n && !(&stat_n);
    last = req && !stat_n[0];
  end

endmodule

// File: rtl/lba_fifo.sv
module lba_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          full,
  output logic          nearly_full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          full_q, nfull_q;
  logic          do_push, do_pop;

  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_q];
  assign do_pop    = out_valid && pop_ready;
  assign do_push   = push && !full_q;
  assign full        = full_q;
  assign nearly_full = nfull_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb cnt_nx = cnt_q + CW'(do_push) - CW'(do_pop);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      nfull_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= wrap_inc(wr_q);
      if (do_pop)  rd_q <= wrap_inc(rd_q);
      cnt_q   <= cnt_nx;
      full_q  <= (cnt_nx == CW'(DEPTH));
      nfull_q <= (cnt_nx == CW'(DEPTH - 1));
    end
  end

endmodule

// File: rtl/lba_ctrl.sv
module lba_ctrl
  import lba_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic last,
  input  logic br_busy,
  input  logic br_req,
  input  logic fifo_full,
  input  logic fifo_nfull,
  input  logic fifo_pop,
  output logic push,
  output logic ae_n,
  output logic de_n,
  output logic rdy_n,
  output logic br_gnt
);

  arb_st_t st_q, st_nx;
  logic    ae_n_q, de_n_q, rdy_n_q, gnt_q;
  logic    accept, held, will_full;

  assign accept = (st_q == ST_DSP) && !rdy_n_q && req;
  assign held   = (st_q == ST_DSP) &&  rdy_n_q && req;
  assign push   = accept;

  // occupancy after this edge reaching depth keeps ready high
  always_comb begin
    if (fifo_full) will_full = !fifo_pop;
    else           will_full = fifo_nfull && accept && !fifo_pop;
  end

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req)         st_nx = br_busy ? ST_WAIT : ST_DSP;
        else if (br_req) st_nx = ST_BRG;
      end
      ST_WAIT: begin
        if (!req)          st_nx = ST_IDLE;
        else if (!br_busy) st_nx = ST_DSP;
      end
      ST_DSP: begin
        if (accept && last)  st_nx = ST_IDLE;
        else if (held && br_req) st_nx = ST_BRK;
      end
      ST_BRG: begin
        if (!br_req) st_nx = ST_IDLE;
      end
      ST_BRK: begin
        if (!br_req) st_nx = req ? ST_WAIT : ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      ae_n_q  <= 1'b1;
      de_n_q  <= 1'b1;
      rdy_n_q <= 1'b1;
      gnt_q   <= 1'b0;
    end else begin
      st_q    <= st_nx;
      ae_n_q  <= (st_nx != ST_DSP);
      de_n_q  <= (st_nx != ST_DSP);
      rdy_n_q <= !((st_nx == ST_DSP) && !will_full);
      gnt_q   <= (st_nx == ST_BRG) || (st_nx == ST_BRK);
    end
  end

  assign ae_n   = ae_n_q;
  assign de_n   = de_n_q;
  assign rdy_n  = rdy_n_q;
  assign br_gnt = gnt_q;

endmodule

// File: rtl/lbus_burst_arb.sv
module lbus_burst_arb #(
  parameter int DW     = 32,
  parameter int DEPTH  = 256,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dsp_strb_n,
  input  logic [STAT_W-1:0] dsp_stat_n,
  input  logic [DW-1:0]     dsp_wdata,
  input  logic              br_busy,
  input  logic              br_req,
  input  logic              drain_ready,
  output logic              dsp_ae_n,
  output logic              dsp_de_n,
  output logic              dsp_rdy_n,
  output logic              br_gnt,
  output logic              drain_valid,
  output logic [DW-1:0]     drain_data
);

  logic req, last, push, fifo_full, fifo_nfull, fifo_pop;

  lba_req_dec #(.STAT_W(STAT_W)) u_dec (
    .strb_n (dsp_strb_n),
    .stat_n (dsp_stat_n),
    .req    (req),
    .last   (last)
  );

  lba_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst         (rst),
    .push        (push),
    .push_data   (dsp_wdata),
    .pop_ready   (drain_ready),
    .out_valid   (drain_valid),
    .out_data    (drain_data),
    .full        (fifo_full),
    .nearly_full (fifo_nfull)
  );

  assign fifo_pop = drain_valid && drain_ready;

  lba_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .last       (last),
    .br_busy    (br_busy),
    .br_req     (br_req),
    .fifo_full  (fifo_full),
    .fifo_nfull (fifo_nfull),
    .fifo_pop   (fifo_pop),
    .push       (push),
    .ae_n       (dsp_ae_n),
    .de_n       (dsp_de_n),
    .rdy_n      (dsp_rdy_n),
    .br_gnt     (br_gnt)
  );

endmodule

// File: rtl/lba_chk.sv
module lba_chk #(
  parameter int STAT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              strb_n,
  input logic [STAT_W-1:0] stat_n,
  input logic              br_busy,
  input logic              br_req,
  input logic              ae_n,
  input logic              de_n,
  input logic              rdy_n,
  input logic              br_gnt,
  input logic              fifo_full
);

  AST_GRANT_AFTER_IDLE_BRIDGE: assert property (@(posedge clk) disable iff (rst)
    $fell(ae_n) |-> $past(!br_busy)) else $error("grant while bridge busy"); // R3

  AST_DE_FOLLOWS_AE: assert property (@(posedge clk) disable iff (rst)
    ae_n == de_n) else $error("enables split"); // R3

  AST_READY_NEEDS_OWNERSHIP: assert property (@(posedge clk) disable iff (rst)
    !rdy_n |-> !ae_n) else $error("ready without ownership"); // R4

  AST_FULL_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> rdy_n) else $error("ready while full"); // R5

  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (!ae_n && !rdy_n && !strb_n && !stat_n[0]) |=> (ae_n && rdy_n))
    else $error("bus kept after last word"); // R6

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
    !(br_gnt && !ae_n)) else $error("two owners"); // R7

  AST_GRANT_DROP: assert property (@(posedge clk) disable iff (rst)
    (br_gnt && !br_req) |=> !br_gnt) else $error("grant kept"); // R10

endmodule

bind lbus_burst_arb lba_chk #(.STAT_W(STAT_W)) u_lba_chk (
  .clk       (clk),
  .rst       (rst),
  .strb_n    (dsp_strb_n),
  .stat_n    (dsp_stat_n),
  .br_busy   (br_busy),
  .br_req    (br_req),
  .ae_n      (dsp_ae_n),
  .de_n      (dsp_de_n),
  .rdy_n     (dsp_rdy_n),
  .br_gnt    (br_gnt),
  .fifo_full (fifo_full)
);

// File: tb/tb_lbus_burst_arb.sv
module tb_lbus_burst_arb;

  localparam int CLK_P  = 30;
  localparam int DW     = 32;
  localparam int DEPTH  = 256;
  localparam int STAT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dsp_strb_n = 1'b1;
  logic [STAT_W-1:0] dsp_stat_n = '1;
  logic [DW-1:0] dsp_wdata = '0;
  logic br_busy = 1'b0, br_req = 1'b0, drain_ready = 1'b0;
  logic dsp_ae_n, dsp_de_n, dsp_rdy_n, br_gnt, drain_valid;
  logic [DW-1:0] drain_data;

  lbus_burst_arb #(.DW(DW), .DEPTH(DEPTH), .STAT_W(STAT_W)) dut (
    .clk(clk), .rst(rst), .dsp_strb_n(dsp_strb_n), .dsp_stat_n(dsp_stat_n),
    .dsp_wdata(dsp_wdata), .br_busy(br_busy), .br_req(br_req),
    .drain_ready(drain_ready), .dsp_ae_n(dsp_ae_n), .dsp_de_n(dsp_de_n),
    .dsp_rdy_n(dsp_rdy_n), .br_gnt(br_gnt), .drain_valid(drain_valid),
    .drain_data(drain_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // ---------------- reference model ----------------
  // owner: 0 idle, 1 waiting, 2 dsp, 3 bridge, 4 bridge breaking a stall
  int           m_own = 0;
  bit           m_ae_n = 1, m_rdy_n = 1, m_gnt = 0, m_acc = 0;
  logic [DW-1:0] m_q[$];
  bit           r_req, r_last, r_acc, r_pop, r_held;
  int           r_nx;

  always @(posedge clk) begin
    if (rst) begin
      m_own = 0; m_ae_n = 1; m_rdy_n = 1; m_gnt = 0; m_acc = 0;
      m_q.delete();
    end else begin
      r_req  = !dsp_strb_n && (dsp_stat_n != '1);
      r_last = r_req && !dsp_stat_n[0];
      r_acc  = (m_own == 2) && !m_rdy_n && r_req;
      r_held = (m_own == 2) && m_rdy_n && r_req;
      r_pop  = (m_q.size() > 0) && drain_ready;
      r_nx   = m_own;
      case (m_own)
        0: if (r_req) r_nx = br_busy ? 1 : 2; else if (br_req) r_nx = 3;
        1: if (!r_req) r_nx = 0; else if (!br_busy) r_nx = 2;
        2: if (r_acc && r_last) r_nx = 0; else if (r_held && br_req) r_nx = 4;
        3: if (!br_req) r_nx = 0;
        default: if (!br_req) r_nx = r_req ? 1 : 0;
      endcase
      if (r_pop) void'(m_q.pop_front());
      if (r_acc) m_q.push_back(dsp_wdata);
      m_rdy_n = !((r_nx == 2) && (m_q.size() < DEPTH));
      m_ae_n  = (r_nx != 2);
      m_gnt   = (r_nx == 3) || (r_nx == 4);
      m_own   = r_nx;
      m_acc   = r_acc;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 ae_n model", DW'(dsp_ae_n), DW'(m_ae_n));
    chk("R3 de_n model", DW'(dsp_de_n), DW'(m_ae_n));
    chk("R4 rdy_n model", DW'(dsp_rdy_n), DW'(m_rdy_n));
    chk("R7 br_gnt model", DW'(br_gnt), DW'(m_gnt));
    chk("R9 drain_valid model", DW'(drain_valid), DW'(m_q.size() > 0));
    if (m_q.size() > 0) chk("R9 drain_data model", drain_data, m_q[0]);
  endtask

  // ---------------- DSP driver ----------------
  int           send_len = 0, send_idx = 0;
  logic [DW-1:0] send_base = '0;
  bit           fake_req = 0;

  task automatic start_burst(input int len, input logic [DW-1:0] base);
    send_len = len; send_idx = 0; send_base = base;
    drive_dsp();
  endtask

  task automatic drive_dsp();
    if (send_idx < send_len) begin
      dsp_strb_n = 1'b0;
      dsp_stat_n = (send_idx == send_len - 1) ? 4'b1110 : 4'b1101;
      dsp_wdata  = send_base + DW'(send_idx);
    end else begin
      dsp_strb_n = fake_req ? 1'b0 : 1'b1;
      dsp_stat_n = '1;
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    if (!rst) compare_all();
    if (m_acc) send_idx++;
    drive_dsp();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ae_n in reset", DW'(dsp_ae_n), 1);
    chk("R1 rdy_n in reset", DW'(dsp_rdy_n), 1);
    rst = 1'b0;
    cycle();
    chk("R1 ae_n after reset", DW'(dsp_ae_n), 1);
    chk("R1 rdy_n after reset", DW'(dsp_rdy_n), 1);
    chk("R1 br_gnt after reset", DW'(br_gnt), 0);
    chk("R1 drain_valid after reset", DW'(drain_valid), 0);

    // R2: strobe low with all status high is not a request
    fake_req = 1; drive_dsp();
    for (int i = 0; i < 4; i++) begin
      cycle();
      chk("R2 no grant on idle status", DW'(dsp_ae_n), 1);
    end
    fake_req = 0; drive_dsp();
    cycle();

    // R3: grant waits for bridge cycle to end
    br_busy = 1'b1;
    start_burst(4, 32'h100);
    for (int i = 0; i < 3; i++) begin
      cycle();
      chk("R3 held while bridge busy", DW'(dsp_ae_n), 1);
    end
    br_busy = 1'b0;
    cycle();
    chk("R3 grant after bridge idle", DW'(dsp_ae_n), 0);
    chk("R4 ready with room", DW'(dsp_rdy_n), 0);
    while (send_idx < send_len) cycle();
    chk("R6 enables released", DW'(dsp_ae_n), 1);
    chk("R6 ready released", DW'(dsp_rdy_n), 1);

    // R9: drain in order
    drain_ready = 1'b1;
    repeat (6) cycle();
    chk("R9 empty after drain", DW'(drain_valid), 0);

    // R7: DSP wins simultaneous request; bridge served afterwards
    br_req = 1'b1;
    start_burst(3, 32'h200);
    cycle();
    chk("R7 dsp wins", DW'(dsp_ae_n), 0);
    chk("R7 no bridge grant", DW'(br_gnt), 0);
    while (send_idx < send_len) cycle();
    cycle();
    chk("R7 bridge granted after burst", DW'(br_gnt), 1);
    br_req = 1'b0;
    cycle();
    chk("R10 bridge grant dropped", DW'(br_gnt), 0);
    repeat (4) cycle();

    // R5: fill the FIFO
    drain_ready = 1'b0;
    start_burst(300, 32'h1000);
    while (m_q.size() < DEPTH) cycle();
    repeat (3) cycle();
    chk("R5 ready high when full", DW'(dsp_rdy_n), 1);
    chk("R5 no word beyond depth", DW'(send_idx), DW'(DEPTH));
    chk("R5 dsp still owns bus", DW'(dsp_ae_n), 0);

    // R8: deadlock, bridge side served first
    br_req = 1'b1;
    cycle();
    chk("R8 bridge granted on stall", DW'(br_gnt), 1);
    chk("R8 dsp enables high", DW'(dsp_ae_n), 1);
    drain_ready = 1'b1;
    repeat (5) cycle();
    chk("R8 ready stays high while bridge served", DW'(dsp_rdy_n), 1);
    br_req = 1'b0;
    cycle();
    chk("R10 grant dropped after stall", DW'(br_gnt), 0);
    cycle();
    chk("R8 dsp regranted", DW'(dsp_ae_n), 0);

    // finish burst with an irregular drain pattern
    for (int k = 0; send_idx < send_len; k++) begin
      drain_ready = (k % 3) != 1;
      cycle();
    end
    drain_ready = 1'b1;
    while (m_q.size() > 0) cycle();
    repeat (2) cycle();
    chk("R9 all drained", DW'(drain_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule